// File: doc/BRIEF.md
# Quadrature Encoder Position Interface

This block turns the two phase signals and the index pulse of an incremental rotary or linear encoder into a 16-bit signed-agnostic position count. Every input is first brought into the clock domain by a two-stage synchronizer. It then passes an optional glitch filter that lets a new level through only once that level has held steady for three filter ticks. The filter tick rate is a power-of-two division of the system clock.

A 3-bit mode field picks how the decoded edges are used. Position modes count either every edge of both phases (x4) or only the edges of phase A (x2). They clear the count on a rising index edge or wrap it against a programmable maximum. A timer mode ignores the encoder and counts prescaled clock ticks, optionally only while a gate input is high. Counter events (index clear, maximum wrap, timer wrap) set a sticky event flag for the interrupt logic. Software reaches the block through a four-word write/read register port.

Top module: `qenc_pos_if`

## Requirements
- R1: After reset the position count is 0, the maximum register is 16'hFFFF, the event flag is 0 and the direction status is 0.
- R2: In x4 modes (mode 3'b110, 3'b111) every change of exactly one phase counts by one. The state order A,B = 00, 10, 11, 01, 00 (A leading B) counts up, and the reverse order counts down.
- R3: In x2 modes (3'b100, 3'b101) only changes of phase A count, up when the new A differs from B and down otherwise. Changes of B alone leave the count unchanged. The direction status (output cnt_dir, CTRL bit 10, 1 = up) takes the direction of each decoded edge.
- R4: In index modes (3'b100, 3'b110) a rising index edge clears the count and sets the event flag, even when a phase edge arrives in the same cycle. Outside of that, the count wraps modulo 2^16 with no event.
- R5: In maximum modes (3'b101, 3'b111) an up count from a value equal to the maximum register gives 0 and sets the event flag.
- R6: In maximum modes a down count from 0 loads the maximum register value and sets the event flag.
- R7: In timer mode (3'b001) the count rises by one every 1, 8, 64 or 256 clocks for CTRL[8:7] = 0, 1, 2, 3. It wraps to 0 with an event after reaching the maximum. With CTRL[9] = 1 it counts only while tmr_gate is high.
- R8: With CTRL[3] = 1, a phase or index level reaches the decoder only after three consecutive equal samples at the filter tick, which occurs every 2^CTRL[6:4] clocks. Shorter pulses are dropped.
- R9: Modes 3'b000, 3'b010 and 3'b011 leave the count unchanged.
- R10: Registers are addressed as 0 = CTRL, 1 = POS (read/write), 2 = MAX (read/write), 3 = reads 0. A POS write overrides a count in the same cycle.
- R11: A CTRL write loads the event flag from bit 11 (the flag also reads back there). A counter event in the same cycle as that write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index pulse |
| tmr_gate | input | 1 | Timer gate level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pos_out | output | 16 | Current count value |
| cnt_dir | output | 1 | Last decoded direction, 1 = up |
| evt_flag | output | 1 | Sticky event flag |

## Verification
Two pairs of functions can land on the same clock edge: a counter event with a software write of the flag, and a count with a software write of the position. The bench drives the timer at divide-by-one so that the edge on which the count wraps is known exactly. It places the clearing CTRL write on that edge and expects the flag still set. It also places a POS write on a counting edge and expects the later count to continue from the written value. The concurrent index clear and phase edge are produced by changing both inputs together, and the expected result is a zero count.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;
  localparam int CNT_W      = 16;
  localparam int PRESC_W    = 8;
  localparam int FDIV_SEL_W = 3;
  localparam int FDIV_W     = (1 << FDIV_SEL_W) - 1;

  localparam logic [2:0] MODE_OFF = 3'b000;
  localparam logic [2:0] MODE_TMR = 3'b001;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_POS  = 2'd1;
  localparam logic [1:0] ADDR_MAX  = 2'd2;

  // One count step: returns {event, next value}.
  function automatic logic [CNT_W:0] count_step(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] lim,
                                                input logic up,
                                                input logic wrap_at_lim);
    logic [CNT_W:0] res;
    if (up) begin
      if (wrap_at_lim && cur == lim) res = {1'b1, {CNT_W{1'b0}}};
      else                           res = {1'b0, cur + 1'b1};
    end else begin
      if (wrap_at_lim && cur == '0)  res = {1'b1, lim};
      else                           res = {1'b0, cur - 1'b1};
    end
    return res;
  endfunction

  // Terminal count of the prescaler: divide by 1, 8, 64, 256.
  function automatic logic [PRESC_W-1:0] presc_limit(input logic [1:0] sel);
    logic [PRESC_W-1:0] r;
    case (sel)
      2'd0:    r = PRESC_W'(0);
      2'd1:    r = PRESC_W'(7);
      2'd2:    r = PRESC_W'(63);
      default: r = PRESC_W'(255);
    endcase
    return r;
  endfunction

  // Mask for the filter tick divider: tick every 2^sel clocks.
  function automatic logic [FDIV_W-1:0] fdiv_mask(input logic [FDIV_SEL_W-1:0] sel);
    logic [FDIV_W:0] one;
    one = (FDIV_W+1)'(1) << sel;
    return FDIV_W'(one - 1'b1);
  endfunction
endpackage

// File: rtl/qenc_filter.sv
`timescale 1ns/1ps
module qenc_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_W       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic filt_en,
  input  logic tick,
  output logic level_out
);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(3);
  localparam logic [RUN_W-1:0] RUN_PASS = RUN_W'(2);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   cand_q;
  logic [RUN_W-1:0]       run_q;
  logic                   held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
  end
  assign synced = sync_q[SYNC_STAGES-1];

  // Third equal sample in a row at the tick moves the held level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      run_q  <= RUN_MAX;
      held_q <= 1'b0;
    end else if (tick) begin
      if (synced != cand_q) begin
        cand_q <= synced;
        run_q  <= RUN_W'(1);
      end else if (run_q != RUN_MAX) begin
        run_q <= run_q + 1'b1;
        if (run_q == RUN_PASS) held_q <= cand_q;
      end
    end
  end

  assign level_out = filt_en ? held_q : synced;

  // R8: the filtered level moves only on a filter tick.
  a_r8_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(held_q));
endmodule

// File: rtl/qenc_decode.sv
`timescale 1ns/1ps
module qenc_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_a,
  input  logic ph_b,
  input  logic idx,
  input  logic x4_sel,
  output logic cnt_step,
  output logic cnt_up,
  output logic idx_rise
);
  logic a_q, b_q, idx_q;
  logic a_edge, b_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      a_q   <= ph_a;
      b_q   <= ph_b;
      idx_q <= idx;
    end
  end

  assign a_edge   = ph_a ^ a_q;
  assign b_edge   = ph_b ^ b_q;
  assign idx_rise = idx & ~idx_q;

  always_comb begin
    if (x4_sel) begin
      cnt_step = a_edge ^ b_edge;
      cnt_up   = a_edge ? (ph_a != ph_b) : (ph_a == ph_b);
    end else begin
      cnt_step = a_edge & ~b_edge;
      cnt_up   = (ph_a != ph_b);
    end
  end

  // R3: in x2 decoding an edge on B never produces a step.
  a_r3_x2_b_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!x4_sel && b_edge) |-> !cnt_step);
endmodule

// File: rtl/qenc_counter.sv
`timescale 1ns/1ps
module qenc_counter
  import qenc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [1:0]       presc_sel,
  input  logic             gate_en,
  input  logic             gate_lvl,
  input  logic             dec_step,
  input  logic             dec_up,
  input  logic             idx_rise,
  input  logic [CNT_W-1:0] max_val,
  input  logic             wr_pos,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] pos,
  output logic             dir_up,
  output logic             cnt_evt
);
  logic               pos_mode, idx_mode, wrap_mode, tmr_mode;
  logic               pos_step, idx_clear, tmr_tick, gate_ok;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   pos_nxt;
  logic [CNT_W:0]     step_res;

  assign pos_mode  = mode[2];
  assign idx_mode  = pos_mode & ~mode[0];
  assign wrap_mode = pos_mode &  mode[0];
  assign tmr_mode  = (mode == MODE_TMR);
  assign gate_ok   = ~gate_en | gate_lvl;

  assign pos_step  = pos_mode & dec_step;
  assign idx_clear = idx_mode & idx_rise;
  assign tmr_tick  = tmr_mode & gate_ok & (presc_q == presc_limit(presc_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                presc_q <= '0;
    else if (!tmr_mode)        presc_q <= '0;
    else if (gate_ok) begin
      if (presc_q == presc_limit(presc_sel)) presc_q <= '0;
      else                                   presc_q <= presc_q + 1'b1;
    end
  end

  // Priority: software write, index clear, encoder step, timer tick.
  always_comb begin
    step_res = count_step(pos, max_val, tmr_tick | dec_up, tmr_tick | wrap_mode);
    pos_nxt  = pos;
    cnt_evt  = 1'b0;
    if (wr_pos) begin
      pos_nxt = wr_data;
    end else if (idx_clear) begin
      pos_nxt = '0;
      cnt_evt = 1'b1;
    end else if (pos_step || tmr_tick) begin
      pos_nxt = step_res[CNT_W-1:0];
      cnt_evt = step_res[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      dir_up <= 1'b0;
    end else begin
      pos <= pos_nxt;
      if (pos_step) dir_up <= dec_up;
    end
  end

  // R5: up count at the maximum wraps to zero.
  a_r5_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_step && dec_up && wrap_mode && !wr_pos && pos == max_val) |=> pos == '0);
  // R6: down count at zero loads the maximum.
  a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_step && !dec_up && wrap_mode && !wr_pos && pos == '0) |=> pos == $past(max_val));
  // R4: index clear wins over a concurrent step.
  a_r4_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_clear && !wr_pos) |=> pos == '0);
  // R9: inactive modes hold the count.
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pos_mode && !tmr_mode && !wr_pos) |=> $stable(pos));
  // R10: a position write always lands.
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pos |=> pos == $past(wr_data));
  // R3: direction follows the last step.
  a_r3_dir_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    pos_step |=> dir_up == $past(dec_up));
endmodule

// File: rtl/qenc_pos_if.sv
`timescale 1ns/1ps
module qenc_pos_if
  import qenc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enc_a,
  input  logic        enc_b,
  input  logic        enc_idx,
  input  logic        tmr_gate,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic [15:0] pos_out,
  output logic        cnt_dir,
  output logic        evt_flag
);
  localparam int N_IN = 3;

  // Control fields
  logic [2:0]            mode_q;
  logic                  filt_en_q;
  logic [FDIV_SEL_W-1:0] fdiv_sel_q;
  logic [1:0]            presc_sel_q;
  logic                  gate_en_q;
  logic [CNT_W-1:0]      max_q;
  logic                  flag_q;

  logic wr_ctrl, wr_pos, wr_max;
  assign wr_ctrl = reg_we && reg_addr == ADDR_CTRL;
  assign wr_pos  = reg_we && reg_addr == ADDR_POS;
  assign wr_max  = reg_we && reg_addr == ADDR_MAX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_OFF;
      filt_en_q   <= 1'b0;
      fdiv_sel_q  <= '0;
      presc_sel_q <= '0;
      gate_en_q   <= 1'b0;
      max_q       <= '1;
    end else begin
      if (wr_ctrl) begin
        mode_q      <= reg_wdata[2:0];
        filt_en_q   <= reg_wdata[3];
        fdiv_sel_q  <= reg_wdata[6:4];
        presc_sel_q <= reg_wdata[8:7];
        gate_en_q   <= reg_wdata[9];
      end
      if (wr_max) max_q <= reg_wdata;
    end
  end

  // Filter tick divider
  logic [FDIV_W-1:0] fdiv_q;
  logic              filt_tick;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fdiv_q <= '0;
    else        fdiv_q <= fdiv_q + 1'b1;
  end
  assign filt_tick = (fdiv_q & fdiv_mask(fdiv_sel_q)) == fdiv_mask(fdiv_sel_q);

  // Input conditioning
  logic [N_IN-1:0] raw_vec, clean_vec;
  assign raw_vec = {enc_idx, enc_b, enc_a};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
    qenc_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (raw_vec[gi]),
      .filt_en  (filt_en_q),
      .tick     (filt_tick),
      .level_out(clean_vec[gi])
    );
  end

  logic [SYNC_STAGES-1:0] gate_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_sync_q <= '0;
    else        gate_sync_q <= {gate_sync_q[SYNC_STAGES-2:0], tmr_gate};
  end

  // Decode and count
  logic dec_step, dec_up, idx_rise, cnt_evt;

  qenc_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph_a    (clean_vec[0]),
    .ph_b    (clean_vec[1]),
    .idx     (clean_vec[2]),
    .x4_sel  (mode_q[1]),
    .cnt_step(dec_step),
    .cnt_up  (dec_up),
    .idx_rise(idx_rise)
  );

  qenc_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .presc_sel(presc_sel_q),
    .gate_en  (gate_en_q),
    .gate_lvl (gate_sync_q[SYNC_STAGES-1]),
    .dec_step (dec_step),
    .dec_up   (dec_up),
    .idx_rise (idx_rise),
    .max_val  (max_q),
    .wr_pos   (wr_pos),
    .wr_data  (reg_wdata),
    .pos      (pos_out),
    .dir_up   (cnt_dir),
    .cnt_evt  (cnt_evt)
  );

  // Event flag: a hardware event beats a software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (cnt_evt) flag_q <= 1'b1;
    else if (wr_ctrl) flag_q <= reg_wdata[11];
  end
  assign evt_flag = flag_q;

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {4'b0, flag_q, cnt_dir, gate_en_q, presc_sel_q,
                              fdiv_sel_q, filt_en_q, mode_q};
      ADDR_POS:  reg_rdata = pos_out;
      ADDR_MAX:  reg_rdata = max_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R11: any counter event leaves the flag set.
  a_r11_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt |=> evt_flag);
endmodule

// File: tb/tb_qenc_pos_if.sv
`timescale 1ns/1ps
module tb_qenc_pos_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, tmr_gate = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata, pos_out;
  logic        cnt_dir, evt_flag;

  int checks = 0;
  int errors = 0;
  int settle = 10;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qenc_pos_if dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .tmr_gate(tmr_gate), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pos_out(pos_out), .cnt_dir(cnt_dir), .evt_flag(evt_flag)
  );

  typedef struct {
    logic [15:0] pos;
    logic        dir;
    logic        flag;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // Monitor: pops expected items and compares against the ports.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (pos_out !== it.pos || cnt_dir !== it.dir || evt_flag !== it.flag) begin
        errors++;
        $display("FAIL %s: pos=%h dir=%b flag=%b expected pos=%h dir=%b flag=%b",
                 it.tag, pos_out, cnt_dir, evt_flag, it.pos, it.dir, it.flag);
      end
    end
  end

  function automatic logic [15:0] mk_ctrl(input logic [2:0] mode, input logic fen,
                                          input logic [2:0] fsel, input logic [1:0] psel,
                                          input logic gen);
    return {6'b0, gen, psel, fsel, fen, mode};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic expect_state(input logic [15:0] p, input logic d, input logic f, input string tag);
    @(negedge clk);
    sb.push_back('{pos: p, dir: d, flag: f, tag: tag});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, reg_rdata, exp);
    end
  endtask

  task automatic port_check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic a, input logic b, input logic i);
    @(negedge clk);
    enc_a = a; enc_b = b; enc_idx = i;
    repeat (settle) @(negedge clk);
  endtask

  // Timer run: counting edges = k + 2 (from ctrl write to stop write inclusive).
  task automatic timer_run(input logic [1:0] psel, input logic gen, input int k);
    wr(2'd0, mk_ctrl(3'b001, 1'b0, 3'd0, psel, gen));
    repeat (k) @(negedge clk);
    wr(2'd0, mk_ctrl(3'b000, 1'b0, 3'd0, 2'd0, 1'b0) | (16'(evt_flag) << 11));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_state(16'h0000, 1'b0, 1'b0, "R1 reset");
    rd_check(2'd2, 16'hFFFF, "R1 max reset");
    rd_check(2'd0, 16'h0000, "R1 ctrl reset");

    // R2 x4 counting, index mode
    wr(2'd0, mk_ctrl(3'b110, 0, 0, 0, 0));
    set_in(1, 0, 0);
    expect_state(16'd1, 1'b1, 1'b0, "R2 x4 first up");
    set_in(1, 1, 0); set_in(0, 1, 0); set_in(0, 0, 0);
    expect_state(16'd4, 1'b1, 1'b0, "R2 x4 four up");
    rd_check(2'd0, mk_ctrl(3'b110, 0, 0, 0, 0) | 16'h0400, "R3 dir bit in ctrl");
    set_in(0, 1, 0); set_in(1, 1, 0);
    expect_state(16'd2, 1'b0, 1'b0, "R2 R3 x4 down");

    // R3 x2 counting
    wr(2'd1, 16'd0);
    wr(2'd0, mk_ctrl(3'b100, 0, 0, 0, 0));
    set_in(0, 1, 0);
    expect_state(16'd1, 1'b1, 1'b0, "R3 x2 A fall up");
    set_in(0, 0, 0);
    expect_state(16'd1, 1'b1, 1'b0, "R3 x2 B edge ignored");
    set_in(1, 0, 0);
    expect_state(16'd2, 1'b1, 1'b0, "R3 x2 A rise up");
    set_in(0, 0, 0);
    expect_state(16'd1, 1'b0, 1'b0, "R3 x2 down");

    // R4 index clear
    set_in(0, 0, 1);
    expect_state(16'd0, 1'b0, 1'b1, "R4 index clear");
    set_in(0, 0, 0);
    wr(2'd0, mk_ctrl(3'b100, 0, 0, 0, 0));
    expect_state(16'd0, 1'b0, 1'b0, "R11 software clear");
    wr(2'd0, mk_ctrl(3'b110, 0, 0, 0, 0));
    wr(2'd1, 16'd5);
    set_in(1, 0, 1);
    expect_state(16'd0, 1'b1, 1'b1, "R4 index beats edge");
    set_in(1, 0, 0);
    wr(2'd0, mk_ctrl(3'b110, 0, 0, 0, 0));
    set_in(0, 0, 0);
    expect_state(16'hFFFF, 1'b0, 1'b0, "R4 plain wrap no event");

    // R5 R6 maximum modes
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd3);
    wr(2'd0, mk_ctrl(3'b111, 0, 0, 0, 0));
    set_in(1, 0, 0);
    expect_state(16'd0, 1'b1, 1'b1, "R5 wrap up at max");
    wr(2'd0, mk_ctrl(3'b111, 0, 0, 0, 0));
    set_in(0, 0, 0);
    expect_state(16'd3, 1'b0, 1'b1, "R6 wrap down to max");
    wr(2'd0, mk_ctrl(3'b111, 0, 0, 0, 0));

    // R9 idle modes
    wr(2'd0, mk_ctrl(3'b010, 0, 0, 0, 0));
    set_in(1, 0, 0);
    expect_state(16'd3, 1'b0, 1'b0, "R9 mode 010 holds");
    wr(2'd0, mk_ctrl(3'b000, 0, 0, 0, 0));
    set_in(0, 0, 0);
    expect_state(16'd3, 1'b0, 1'b0, "R9 mode 000 holds");

    // R8 filter
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'd0);
    wr(2'd0, mk_ctrl(3'b110, 1, 3'd0, 0, 0));
    @(negedge clk); enc_a = 1'b1;
    repeat (2) @(negedge clk); enc_a = 1'b0;
    repeat (12) @(negedge clk);
    expect_state(16'd0, 1'b0, 1'b0, "R8 short glitch dropped");
    set_in(1, 0, 0);
    expect_state(16'd1, 1'b1, 1'b0, "R8 steady level passes");
    wr(2'd0, mk_ctrl(3'b110, 1, 3'd2, 0, 0));
    settle = 40;
    @(negedge clk); enc_a = 1'b0;
    repeat (6) @(negedge clk); enc_a = 1'b1;
    repeat (40) @(negedge clk);
    expect_state(16'd1, 1'b1, 1'b0, "R8 glitch at divided tick dropped");
    set_in(0, 0, 0);
    expect_state(16'd0, 1'b0, 1'b0, "R8 divided tick passes");
    settle = 10;
    wr(2'd0, mk_ctrl(3'b000, 0, 0, 0, 0));

    // R7 timer
    wr(2'd1, 16'd0);
    timer_run(2'd0, 1'b0, 18);
    rd_check(2'd1, 16'd20, "R7 timer div1");
    wr(2'd1, 16'd0);
    timer_run(2'd1, 1'b0, 38);
    rd_check(2'd1, 16'd5, "R7 timer div8");
    wr(2'd1, 16'd0);
    tmr_gate = 1'b0;
    repeat (4) @(negedge clk);
    timer_run(2'd0, 1'b1, 8);
    rd_check(2'd1, 16'd0, "R7 gate low stops");
    tmr_gate = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd1, 16'd0);
    timer_run(2'd0, 1'b1, 8);
    rd_check(2'd1, 16'd10, "R7 gate high counts");
    wr(2'd2, 16'd9);
    wr(2'd1, 16'd0);
    timer_run(2'd0, 1'b0, 10);
    rd_check(2'd1, 16'd2, "R7 timer wrap at max");
    @(negedge clk); port_check(evt_flag, 1'b1, "R7 timer wrap event");

    // R11 event and clearing write on the same edge
    wr(2'd0, mk_ctrl(3'b000, 0, 0, 0, 0));
    @(negedge clk); port_check(evt_flag, 1'b0, "R11 clear by write");
    wr(2'd2, 16'd4);
    wr(2'd1, 16'd0);
    wr(2'd0, mk_ctrl(3'b001, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    wr(2'd0, mk_ctrl(3'b001, 0, 0, 0, 0));
    @(negedge clk); port_check(evt_flag, 1'b1, "R11 event beats clear");
    wr(2'd0, mk_ctrl(3'b000, 0, 0, 0, 0));

    // R10 position write beats a count
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'd0);
    wr(2'd0, mk_ctrl(3'b001, 0, 0, 0, 0));
    wr(2'd1, 16'd100);
    wr(2'd0, mk_ctrl(3'b000, 0, 0, 0, 0));
    rd_check(2'd1, 16'd102, "R10 write wins over count");
    rd_check(2'd3, 16'd0, "R10 unused address");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule